// File: doc/BRIEF.md
# MPU region permission checker

This block guards memory accesses with a set of programmable protection regions. Each region has a base address, a power-of-two size with an enable flag, and an access-control word holding execute-never, a three-bit permission code and a three-bit memory type. Every access presented to the checker carries an address, a kind (instruction fetch, data read or data write) and a privilege level. One cycle later the block reports whether the access is permitted, and if not, whether it is a permission fault or a background fault. It also reports whether the faulting access was a fetch, so the processor can raise a prefetch abort rather than a data abort. It reports the memory class of the region that decided the outcome as well.

Software reaches the region registers indirectly. It writes a region number to the select register, then reads or writes that region's base, size/enable and access-control registers. A separate control register enables a background map for privileged accesses that hit no region. Regions may overlap; the highest-numbered enabled region that matches wins.

Fetches are stricter than data reads. A fetch also needs data-read permission at the current privilege. Fetches from strongly ordered or device regions are refused as if execute-never were set.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset, all regions are disabled, the select, base, size, access and control registers read back zero, and every access ends in a background fault with class 3.
- R2: Config offsets are: 0 selects a region (low 3 bits); 1, 2 and 3 read or write the selected region's base, size/enable and access words; 4 is control. The base reads back with bits 4:0 cleared. The size word reads back bits 5:0. The access word reads back bits 12, 10:8 and 2:0.
- R3: Size word bit 0 enables the region, and bits 5:1 hold code c. The region spans 2^(c+1) bytes, and an address matches when all bits above bit c equal the base. A code of 31 matches the whole space, and codes below 4 never match.
- R4: Permission code (access bits 10:8) grants as follows. 1: privileged read/write. 2: privileged read/write, user read. 3: read/write for both levels. 5: privileged read. 6: read for both levels. 0, 4 and 7: nothing. A denied data access on a matched region gives a permission fault.
- R5: Access bit 12 set makes every fetch from the region a permission fault.
- R6: Memory type (access bits 2:0) 0 is strongly ordered (class 0), 1 is device (class 1), and others are normal (class 2). A fetch from class 0 or 1 faults whatever bit 12 holds.
- R7: A fetch is permitted only if the region grants data read at the access's privilege, bit 12 is clear and the class is normal.
- R8: When several enabled regions match, the highest-numbered one decides the outcome and the class.
- R9: When no region matches, a privileged access is permitted with class 2 if control bit 0 is set. A user access, or any access with that bit clear, is a background fault.
- R10: A request with acc_valid high gives res_valid high on the next cycle, with exactly one of permit, permission fault and background fault set. res_ifetch is set only for a faulting fetch (kind 0). Kind 1 is a read; kinds 2 and 3 are writes. With no request, res_valid is low on the next cycle.
- R11: res_mtype reports the class of the deciding region, 2 for a background permit, and 3 for a background fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config register offset |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_addr (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 fetch, 1 read, 2/3 write |
| acc_priv | input | 1 | 1 privileged, 0 user |
| res_valid | output | 1 | Result present |
| res_permit | output | 1 | Access allowed |
| res_perm_fault | output | 1 | Matched region refused the access |
| res_bg_fault | output | 1 | No region matched and no background grant |
| res_ifetch | output | 1 | Fault was on an instruction fetch |
| res_mtype | output | 2 | Class: 0 strongly ordered, 1 device, 2 normal, 3 none |

## Verification
One whole-space region is swept through every permission code, every memory type and both execute-never settings, under all access kinds and both privileges. This sweep separates the data permission table from the stricter fetch rule and from the type-forced execute-never. Size codes are probed just inside and just outside each region's edges, including the 256 MB code and codes below the minimum, to expose off-by-one masking. Pseudo-random overlapping layouts, with the background map both on and off, test whether the highest-numbered region wins and how the no-match cases are handled.

// File: rtl/mpu_pkg.sv
// Package: shared types, field positions and decode functions for the
// MPU region checker. Assumes a 32-bit config data path.
package mpu_pkg;

    localparam int CFG_W          = 32;
    localparam int XN_BIT         = 12;
    localparam int AP_LO          = 8;
    localparam int MIN_SIZE_CODE  = 4;
    localparam int BASE_LOW_ZERO  = 5;

    localparam logic [2:0] OFS_SELECT  = 3'd0;
    localparam logic [2:0] OFS_BASE    = 3'd1;
    localparam logic [2:0] OFS_SIZE    = 3'd2;
    localparam logic [2:0] OFS_ACCESS  = 3'd3;
    localparam logic [2:0] OFS_CONTROL = 3'd4;

    typedef enum logic [1:0] {
        AK_FETCH = 2'd0,
        AK_READ  = 2'd1,
        AK_WRITE = 2'd2,
        AK_WALT  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        MC_STRONG = 2'd0,
        MC_DEVICE = 2'd1,
        MC_NORMAL = 2'd2,
        MC_NONE   = 2'd3
    } mem_class_e;

    typedef struct packed {
        logic       xn;
        logic [2:0] ap;
        logic [2:0] mtype;
    } acc_ctl_t;

    typedef struct packed {
        logic [4:0] code;
        logic       en;
    } size_ctl_t;

    // Data read grant for a permission code at a privilege level.
    function automatic logic ap_read_ok(input logic [2:0] ap, input logic priv);
        case (ap)
            3'd1, 3'd5:       return priv;
            3'd2, 3'd3, 3'd6: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    // Data write grant for a permission code at a privilege level.
    function automatic logic ap_write_ok(input logic [2:0] ap, input logic priv);
        case (ap)
            3'd1, 3'd2: return priv;
            3'd3:       return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

    // Memory class from the raw type field.
    function automatic mem_class_e type_class(input logic [2:0] mtype);
        case (mtype)
            3'd0:    return MC_STRONG;
            3'd1:    return MC_DEVICE;
            default: return MC_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
// Region register file with indirect access through a select register.
// Holds base, size/enable and access-control per region plus a control
// register with the background-enable bit. Reads are combinational.
// Assumes NREG is a power of two.
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_addr,
    input  logic [CFG_W-1:0]             cfg_wdata,
    output logic [CFG_W-1:0]             cfg_rdata,
    output logic [NREG-1:0][AW-1:0]      base_o,
    output size_ctl_t [NREG-1:0]         size_o,
    output acc_ctl_t  [NREG-1:0]         ctl_o,
    output logic                         bg_en_o
);
    localparam int RGN_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [RGN_W-1:0] rgn_sel;

    // Select register and background enable update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_sel <= '0;
            bg_en_o <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == OFS_SELECT)  rgn_sel <= cfg_wdata[RGN_W-1:0];
            if (cfg_addr == OFS_CONTROL) bg_en_o <= cfg_wdata[0];
        end
    end

    // Per-region storage, written only when that region is selected.
    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[r] <= '0;
                size_o[r] <= '0;
                ctl_o[r]  <= '0;
            end else if (cfg_we && rgn_sel == RGN_W'(r)) begin
                case (cfg_addr)
                    OFS_BASE:   base_o[r] <= {cfg_wdata[AW-1:BASE_LOW_ZERO], {BASE_LOW_ZERO{1'b0}}};
                    OFS_SIZE:   size_o[r] <= cfg_wdata[5:0];
                    OFS_ACCESS: ctl_o[r]  <= '{xn: cfg_wdata[XN_BIT],
                                               ap: cfg_wdata[AP_LO+2:AP_LO],
                                               mtype: cfg_wdata[2:0]};
                    default: ;
                endcase
            end
        end
    end

    // Read mux for the selected register.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_SELECT:  cfg_rdata[RGN_W-1:0] = rgn_sel;
            OFS_BASE:    cfg_rdata[AW-1:0]    = base_o[rgn_sel];
            OFS_SIZE:    cfg_rdata[5:0]       = size_o[rgn_sel];
            OFS_ACCESS: begin
                cfg_rdata[XN_BIT]           = ctl_o[rgn_sel].xn;
                cfg_rdata[AP_LO+2:AP_LO]    = ctl_o[rgn_sel].ap;
                cfg_rdata[2:0]              = ctl_o[rgn_sel].mtype;
            end
            OFS_CONTROL: cfg_rdata[0]         = bg_en_o;
            default:     cfg_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/mpu_region_match.sv
// Address comparator for one region. A region of size code c spans
// 2^(c+1) bytes; only address bits above bit c are compared, so the base
// is assumed aligned. Codes below the minimum never match.
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  size_ctl_t     size,
    output logic          hit
);
    // Compare every bit above the size code.
    always_comb begin
        hit = size.en && (int'(size.code) >= MIN_SIZE_CODE);
        for (int i = 0; i < AW; i++) begin
            if (i > int'(size.code) && addr[i] != base[i]) hit = 1'b0;
        end
    end
endmodule

// File: rtl/mpu_prio_select.sv
// Picks the highest-numbered hitting region and forwards its access
// control. Assumes hits are already qualified by enable.
module mpu_prio_select
    import mpu_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [NREG-1:0]      hits,
    input  acc_ctl_t [NREG-1:0]  ctl,
    output logic                 any_hit,
    output acc_ctl_t             sel_ctl
);
    // Ascending scan so later (higher) regions override earlier ones.
    always_comb begin
        any_hit = 1'b0;
        sel_ctl = '0;
        for (int r = 0; r < NREG; r++) begin
            if (hits[r]) begin
                any_hit = 1'b1;
                sel_ctl = ctl[r];
            end
        end
    end
endmodule

// File: rtl/mpu_perm_eval.sv
// Decides permit/fault for one access from the winning region's control
// or the background map. Fetches need read permission, clear XN and a
// normal memory class.
module mpu_perm_eval
    import mpu_pkg::*;
(
    input  logic       any_hit,
    input  acc_ctl_t   sel_ctl,
    input  logic       bg_en,
    input  logic [1:0] kind,
    input  logic       priv,
    output logic       permit,
    output logic       perm_fault,
    output logic       bg_fault,
    output logic       ifetch,
    output logic [1:0] mclass
);
    acc_kind_e  k;
    mem_class_e cls;
    logic       rd_ok;
    logic       wr_ok;
    logic       ok;

    assign k     = acc_kind_e'(kind);
    assign cls   = type_class(sel_ctl.mtype);
    assign rd_ok = ap_read_ok(sel_ctl.ap, priv);
    assign wr_ok = ap_write_ok(sel_ctl.ap, priv);

    // Region-level grant by access kind.
    always_comb begin
        case (k)
            AK_FETCH: ok = rd_ok && !sel_ctl.xn && (cls == MC_NORMAL);
            AK_READ:  ok = rd_ok;
            default:  ok = wr_ok;
        endcase
    end

    // Outcome selection: region, background grant or background fault.
    always_comb begin
        permit     = 1'b0;
        perm_fault = 1'b0;
        bg_fault   = 1'b0;
        mclass     = MC_NONE;
        if (any_hit) begin
            permit     = ok;
            perm_fault = !ok;
            mclass     = cls;
        end else if (bg_en && priv) begin
            permit = 1'b1;
            mclass = MC_NORMAL;
        end else begin
            bg_fault = 1'b1;
        end
    end

    assign ifetch = (perm_fault || bg_fault) && (k == AK_FETCH);
endmodule

// File: rtl/mpu_region_guard.sv
// Top of the MPU region checker: register file, one comparator per
// region, priority pick, permission evaluation and a result register.
// Results appear one cycle after a valid request.
module mpu_region_guard
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic [1:0]       acc_kind,
    input  logic             acc_priv,
    output logic             res_valid,
    output logic             res_permit,
    output logic             res_perm_fault,
    output logic             res_bg_fault,
    output logic             res_ifetch,
    output logic [1:0]       res_mtype
);
    logic [NREG-1:0][AW-1:0] base;
    size_ctl_t [NREG-1:0]    size;
    acc_ctl_t  [NREG-1:0]    ctl;
    logic                    bg_en;
    logic [NREG-1:0]         hits;
    logic                    any_hit;
    acc_ctl_t                sel_ctl;
    logic                    c_permit, c_pf, c_bf, c_if;
    logic [1:0]              c_cls;

    mpu_cfg_regs #(.NREG(NREG), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .base_o(base), .size_o(size), .ctl_o(ctl), .bg_en_o(bg_en)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_match
        mpu_region_match #(.AW(AW)) u_match (
            .addr(acc_addr), .base(base[r]), .size(size[r]), .hit(hits[r])
        );
    end

    mpu_prio_select #(.NREG(NREG)) u_prio (
        .hits(hits), .ctl(ctl), .any_hit(any_hit), .sel_ctl(sel_ctl)
    );

    mpu_perm_eval u_eval (
        .any_hit(any_hit), .sel_ctl(sel_ctl), .bg_en(bg_en),
        .kind(acc_kind), .priv(acc_priv),
        .permit(c_permit), .perm_fault(c_pf), .bg_fault(c_bf),
        .ifetch(c_if), .mclass(c_cls)
    );

    // Result register: captures the decision of each valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_permit     <= 1'b0;
            res_perm_fault <= 1'b0;
            res_bg_fault   <= 1'b0;
            res_ifetch     <= 1'b0;
            res_mtype      <= 2'd0;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_permit     <= c_permit;
                res_perm_fault <= c_pf;
                res_bg_fault   <= c_bf;
                res_ifetch     <= c_if;
                res_mtype      <= c_cls;
            end
        end
    end
endmodule

// File: rtl/mpu_region_guard_chk.sv
// Checker for mpu_region_guard: protocol and outcome properties at the
// ports. Attached by bind below.
module mpu_region_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [1:0] acc_kind,
    input logic       res_valid,
    input logic       res_permit,
    input logic       res_perm_fault,
    input logic       res_bg_fault,
    input logic       res_ifetch,
    input logic [1:0] res_mtype
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid); // R10
    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_permit, res_perm_fault, res_bg_fault}) == 1); // R10
    AST_IFETCH_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 2'd0) |=> !res_ifetch); // R10
    AST_NO_EXEC_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd0) |=> !(res_permit && res_mtype != 2'd2)); // R6
    AST_BG_FAULT_NO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_bg_fault) |-> res_mtype == 2'd3); // R11
endmodule

bind mpu_region_guard mpu_region_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .res_valid(res_valid), .res_permit(res_permit),
    .res_perm_fault(res_perm_fault), .res_bg_fault(res_bg_fault),
    .res_ifetch(res_ifetch), .res_mtype(res_mtype)
);

// File: tb/mpu_region_guard_test.sv
`timescale 1ns/1ps
module mpu_region_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0;
    logic        res_valid, res_permit, res_perm_fault, res_bg_fault, res_ifetch;
    logic [1:0]  res_mtype;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] sh_base [8];
    logic [5:0]  sh_size [8];
    logic [12:0] sh_acc  [8];
    logic        sh_bg;
    logic [31:0] seed = 32'h1234_abcd;

    always #4 clk = ~clk;

    mpu_region_guard uut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_region(input int r, input logic [31:0] b, input logic [5:0] sz, input logic [12:0] ac);
        cfg_write(3'd0, r);
        cfg_write(3'd1, b);
        cfg_write(3'd2, {26'd0, sz});
        cfg_write(3'd3, {19'd0, ac});
        sh_base[r] = b & 32'hFFFF_FFE0;
        sh_size[r] = sz;
        sh_acc[r]  = ac & 13'h1707;
    endtask

    task automatic set_bg(input logic v);
        cfg_write(3'd4, {31'd0, v});
        sh_bg = v;
    endtask

    function automatic logic rd_grant(input logic [2:0] ap, input logic p);
        if (ap == 3'd2 || ap == 3'd3 || ap == 3'd6) return 1'b1;
        if (ap == 3'd1 || ap == 3'd5) return p;
        return 1'b0;
    endfunction

    function automatic logic wr_grant(input logic [2:0] ap, input logic p);
        if (ap == 3'd3) return 1'b1;
        if (ap == 3'd1 || ap == 3'd2) return p;
        return 1'b0;
    endfunction

    // Expected {valid, permit, pfault, bgfault, ifetch, class[1:0]}.
    function automatic logic [6:0] model(input logic [31:0] a, input logic [1:0] k, input logic p);
        int win = -1;
        logic ok, rd;
        logic [1:0] cls;
        for (int r = 0; r < 8; r++) begin
            int c = int'(sh_size[r][5:1]);
            if (sh_size[r][0] && c >= 4) begin
                if (c + 1 >= 32) win = r;
                else if ((a >> (c + 1)) == (sh_base[r] >> (c + 1))) win = r;
            end
        end
        if (win >= 0) begin
            logic [12:0] w = sh_acc[win];
            cls = (w[2:0] == 3'd0) ? 2'd0 : (w[2:0] == 3'd1) ? 2'd1 : 2'd2;
            rd  = rd_grant(w[10:8], p);
            if (k == 2'd0)      ok = rd && !w[12] && cls == 2'd2;
            else if (k == 2'd1) ok = rd;
            else                ok = wr_grant(w[10:8], p);
            return {1'b1, ok, !ok, 1'b0, (!ok && k == 2'd0), cls};
        end
        if (sh_bg && p) return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2};
        return {1'b1, 1'b0, 1'b0, 1'b1, (k == 2'd0), 2'd3};
    endfunction

    task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic p, input string tag);
        logic [6:0] got;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
        @(negedge clk);
        acc_valid = 1'b0;
        got = {res_valid, res_permit, res_perm_fault, res_bg_fault, res_ifetch, res_mtype};
        check(tag, {25'd0, got}, {25'd0, model(a, k, p)});
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    initial begin
        logic [31:0] d;
        for (int r = 0; r < 8; r++) begin
            sh_base[r] = '0; sh_size[r] = '0; sh_acc[r] = '0;
        end
        sh_bg = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of registers and outputs
        check("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
        for (int a = 0; a < 5; a++) begin
            cfg_read(a[2:0], d);
            check("R1 register reads zero", d, 32'd0);
        end
        probe(32'h0000_0000, 2'd0, 1'b1, "R1 priv fetch bg fault");
        probe(32'h8000_0000, 2'd2, 1'b0, "R1 user write bg fault");

        // R2: indirect readback across every region
        for (int r = 0; r < 8; r++)
            set_region(r, 32'hA5A5_A5FF ^ (r << 20), 6'h3E ^ r[5:0], 13'h1FFF ^ r[12:0]);
        for (int r = 0; r < 8; r++) begin
            cfg_write(3'd0, r);
            cfg_read(3'd0, d); check("R2 select readback", d, r);
            cfg_read(3'd1, d); check("R2 base readback", d, {26'd0, sh_base[r][31:26]} << 26 | sh_base[r]);
            cfg_read(3'd2, d); check("R2 size readback", d, {26'd0, sh_size[r]});
            cfg_read(3'd3, d); check("R2 access readback", d, {19'd0, sh_acc[r]});
        end
        set_bg(1'b1);
        cfg_read(3'd4, d); check("R2 control readback", d, 32'd1);
        for (int r = 0; r < 8; r++) set_region(r, 0, 6'd0, 13'd0);
        set_bg(1'b0);

        // R4 R5 R6 R7 R11: whole-space region swept over every attribute
        for (int ap = 0; ap < 8; ap++)
            for (int mt = 0; mt < 8; mt++)
                for (int xn = 0; xn < 2; xn++) begin
                    set_region(0, 0, {5'd31, 1'b1}, {xn[0], 1'b0, ap[2:0], 5'b0, mt[2:0]});
                    for (int k = 0; k < 4; k++)
                        for (int p = 0; p < 2; p++) begin
                            string tag;
                            if (k != 0)      tag = "R4/R11 data access";
                            else if (xn == 1) tag = "R5 fetch with XN";
                            else if (mt < 2) tag = "R6 fetch uncached type";
                            else             tag = "R7 fetch needs read";
                            probe(32'h1234_5678, k[1:0], p[0], tag);
                        end
                end
        set_region(0, 0, 6'd0, 13'd0);

        // R3: size edges, minimum code and the 256 MB code
        for (int c = 2; c < 13; c++) begin
            logic [31:0] b = 32'h0001_0000;
            logic [31:0] sz = 32'd1 << (c + 1);
            set_region(1, b, {c[4:0], 1'b1}, 13'h0302);
            probe(b,           2'd1, 1'b1, "R3 first byte");
            probe(b + sz - 1,  2'd1, 1'b1, "R3 last byte");
            probe(b + sz,      2'd1, 1'b1, "R3 past end");
            probe(b - 1,       2'd1, 1'b1, "R3 before base");
        end
        set_region(1, 32'h6000_0000, {5'h1B, 1'b1}, 13'h0302);
        probe(32'h6000_0000, 2'd2, 1'b0, "R3 256MB base");
        probe(32'h6FFF_FFFF, 2'd2, 1'b0, "R3 256MB top");
        probe(32'h7000_0000, 2'd2, 1'b0, "R3 256MB beyond");
        set_region(1, 32'h6000_0000, {5'h1B, 1'b0}, 13'h0302);
        probe(32'h6000_0000, 2'd1, 1'b1, "R3 disabled region");
        set_region(1, 0, 6'd0, 13'd0);

        // R9: background map with no regions
        for (int bg = 0; bg < 2; bg++) begin
            set_bg(bg[0]);
            for (int k = 0; k < 4; k++)
                for (int p = 0; p < 2; p++)
                    probe(32'hC000_1000, k[1:0], p[0], "R9 background");
        end

        // R8: overlapping pseudo-random layouts
        for (int t = 0; t < 20; t++) begin
            for (int r = 0; r < 8; r++) begin
                int c;
                logic [31:0] msk;
                seed = lcg(seed);
                c = 4 + int'(seed[19:16]);
                msk = ~((32'd1 << (c + 1)) - 1);
                seed = lcg(seed);
                set_region(r, seed & 32'h000F_FFFF & msk, {c[4:0], seed[31] | seed[29]},
                           {seed[28], 1'b0, seed[26:24], 5'b0, seed[22:20]});
            end
            seed = lcg(seed);
            set_bg(seed[30]);
            for (int q = 0; q < 24; q++) begin
                seed = lcg(seed);
                for (int k = 0; k < 4; k++)
                    for (int p = 0; p < 2; p++)
                        probe((q < 20) ? (seed & 32'h000F_FFFF) : (seed | 32'h0010_0000),
                              k[1:0], p[0], "R8 overlap winner");
            end
        end

        // R10: no request gives no result
        @(negedge clk);
        @(negedge clk);
        check("R10 idle no result", {31'd0, res_valid}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule